// File: doc/BRIEF.md
# Pulse Width Count Timer

An 8-bit down-counting timer with two modes, driven through a small register port. In interval mode the counter loads a programmed start value and steps down by one on each pulse of a chosen count-tick input. Each pass through one to zero raises an underflow flag, and the count restarts by itself. In measurement mode the block times a pulse on an external input. The input passes through a two-stage synchronizer. A start edge arms the counter at all ones, a programmable completion edge ends the interval, and the elapsed tick count is stored in the hold register.

Three sticky status flags feed one level interrupt, which is gated by an interrupt-enable bit. The flags are underflow, measurement complete and hold full. Stopping the timer in the same cycle as an event suppresses that event's flags. Enabling the interrupt while a flag is already pending asserts the interrupt at once. The tick prescaler, interrupt priority and vectoring sit outside the block.

Top module: `pwc_timer`

## Requirements
- R1: After reset, the control (address 0), status (address 1) and hold (address 2) registers read 0 and `irq_o` is 0. Control bits: [0] run, [1] irq enable, [2] mode (1 = measure), [4:3] edge select, [6:5] tick select. Status bits: [0] underflow, [1] complete, [2] full.
- R2: In interval mode while running, a counter at 0 loads the hold value on the next cycle. Each selected tick decrements it, and a 1-to-0 step sets underflow. So with hold value N, every run of N selected ticks after a load raises underflow, and the count continues without software help.
- R3: Only `tick_i[tick select]` decrements the counter. Pulses on the other tick lines have no effect.
- R4: In measure mode, edge select 00 times rising to falling, 01 falling to rising, and 10 or 11 rising to rising. The counter loads all ones on the start edge. The hold register receives the number of selected ticks seen strictly between the start and the completion edge; with a tick on every cycle, a pulse W cycles long captures W-1. A 0-to-1 write of run re-arms the block to wait for a start edge.
- R5: A completion edge sets both complete and full. A long pulse that steps the counter from 1 to 0 also sets underflow, and the capture wraps modulo 256.
- R6: Writing 0 to status bit 0 or 1 clears that flag. Writing 1 leaves it unchanged. Bit 2 is not writable.
- R7: A read of the hold register clears full and leaves complete unchanged.
- R8: When a flag set event and a clearing access happen in the same cycle, the flag ends up 1.
- R9: A control write with run 0 in the same cycle as an interval underflow leaves the underflow flag clear.
- R10: A control write with run 0 in the same cycle as a completion edge sets neither complete nor full and leaves the hold register unchanged.
- R11: While run is 0, the counter keeps its value and ignores ticks and input edges. After a restart it continues from the held count.
- R12: `irq_o` is 1 exactly when interrupt enable is 1 and any flag is 1. A control write that sets enable while a flag is pending raises `irq_o` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | NUM_TICKS | Count-tick strobes from the prescaler, one per rate |
| pulse_i | input | 1 | Asynchronous input whose pulse is measured |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (reading hold clears full) |
| addr_i | input | 2 | Register address: 0 control, 1 status, 2 hold |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for `addr_i`, valid in the same cycle |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A counter that skips or repeats a step shows up as an underflow flag that appears one tick early or late, or as a captured width off by one. This is visible at the first underflow or the first completed measurement. A stale measurement state, such as a measurer that stays armed after a stop, corrupts the next capture. A wrong flag update shows in the status register or on `irq_o` in the cycle right after the offending access. The stop-coincidence and set-over-clear cases are driven in exactly the colliding cycle, because one cycle of misalignment would hide them.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_HOLD = 2'd2;

    // control register bit positions
    localparam int CTRL_RUN  = 0;
    localparam int CTRL_IE   = 1;
    localparam int CTRL_MEAS = 2;
    localparam int CTRL_ESEL = 3;
    localparam int CTRL_TSEL = 5;

    // status register bit positions
    localparam int ST_UF   = 0;
    localparam int ST_DONE = 1;
    localparam int ST_FULL = 2;

    typedef enum logic [1:0] {
        EDGE_RISE_FALL = 2'b00,
        EDGE_FALL_RISE = 2'b01,
        EDGE_RISE_RISE = 2'b10,
        EDGE_RISE_RIS2 = 2'b11
    } edge_sel_e;
endpackage

// File: rtl/pwc_edge_sync.sv
module pwc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);
    // STAGES synchronizer flops plus one history flop
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], sig_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
    assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/pwc_tick_sel.sv
module pwc_tick_sel #(
    parameter int NUM_TICKS = 4,
    parameter int SEL_W     = 2
) (
    input  logic [NUM_TICKS-1:0] tick_i,
    input  logic [SEL_W-1:0]     sel_i,
    output logic                 tick_o
);
    logic [NUM_TICKS-1:0] hit;

    for (genvar g = 0; g < NUM_TICKS; g++) begin : g_hit
        assign hit[g] = tick_i[g] && (sel_i == SEL_W'(g));
    end

    assign tick_o = |hit;
endmodule

// File: rtl/pwc_timer.sv
module pwc_timer
    import pwc_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int NUM_TICKS = 4,
    parameter int SYNC_LEN  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TICKS-1:0] tick_i,
    input  logic                 pulse_i,
    input  logic                 wr_en_i,
    input  logic                 rd_en_i,
    input  logic [1:0]           addr_i,
    input  logic [CNT_W-1:0]     wdata_i,
    output logic [CNT_W-1:0]     rdata_o,
    output logic                 irq_o
);
    localparam int SEL_W = (NUM_TICKS > 1) ? $clog2(NUM_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
        logic             run;
        logic             ie;
        logic             meas;
        edge_sel_e        esel;
        logic [SEL_W-1:0] tsel;
        logic             uf;
        logic             done;
        logic             full;
        logic             active;
    } state_t;

    state_t s_d, s_q;

    logic tick_hit, in_rise, in_fall;
    logic wr_ctrl, wr_stat, wr_hold, rd_hold, stop_now, run_eff;
    logic start_edge, end_edge, set_uf, set_cmp;
    logic [CNT_W-1:0] ctrl_rd;

    pwc_tick_sel #(.NUM_TICKS(NUM_TICKS), .SEL_W(SEL_W)) u_tick (
        .tick_i (tick_i),
        .sel_i  (s_q.tsel),
        .tick_o (tick_hit)
    );

    pwc_edge_sync #(.STAGES(SYNC_LEN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (pulse_i),
        .rise_o (in_rise),
        .fall_o (in_fall)
    );

    assign wr_ctrl  = wr_en_i && (addr_i == ADDR_CTRL);
    assign wr_stat  = wr_en_i && (addr_i == ADDR_STAT);
    assign wr_hold  = wr_en_i && (addr_i == ADDR_HOLD);
    assign rd_hold  = rd_en_i && (addr_i == ADDR_HOLD);
    assign stop_now = wr_ctrl && !wdata_i[CTRL_RUN];
    assign run_eff  = s_q.run && !stop_now;

    assign start_edge = (s_q.esel == EDGE_FALL_RISE) ? in_fall : in_rise;
    assign end_edge   = (s_q.esel == EDGE_RISE_FALL) ? in_fall : in_rise;

    always_comb begin
        s_d     = s_q;
        set_uf  = 1'b0;
        set_cmp = 1'b0;

        if (wr_ctrl) begin
            s_d.run  = wdata_i[CTRL_RUN];
            s_d.ie   = wdata_i[CTRL_IE];
            s_d.meas = wdata_i[CTRL_MEAS];
            s_d.esel = edge_sel_e'(wdata_i[CTRL_ESEL +: 2]);
            s_d.tsel = wdata_i[CTRL_TSEL +: SEL_W];
            // leaving measure mode or starting from stop re-arms the measurer
            if (!wdata_i[CTRL_MEAS] || (wdata_i[CTRL_RUN] && !s_q.run))
                s_d.active = 1'b0;
        end

        if (wr_hold)
            s_d.hold = wdata_i;

        if (run_eff) begin
            if (!s_q.meas) begin
                if (s_q.cnt == '0) begin
                    s_d.cnt = s_q.hold;
                end else if (tick_hit) begin
                    s_d.cnt = s_q.cnt - CNT_ONE;
                    set_uf  = (s_q.cnt == CNT_ONE);
                end
            end else if (!s_q.active) begin
                if (start_edge) begin
                    s_d.cnt    = CNT_MAX;
                    s_d.active = 1'b1;
                end
            end else if (end_edge) begin
                s_d.hold   = ~s_q.cnt;
                s_d.active = 1'b0;
                set_cmp    = 1'b1;
            end else if (tick_hit) begin
                s_d.cnt = s_q.cnt - CNT_ONE;
                set_uf  = (s_q.cnt == CNT_ONE);
            end
        end

        // sticky flags: set beats clear, writing 1 keeps the value
        s_d.uf   = set_uf  | (s_q.uf   & ~(wr_stat && !wdata_i[ST_UF]));
        s_d.done = set_cmp | (s_q.done & ~(wr_stat && !wdata_i[ST_DONE]));
        s_d.full = set_cmp | (s_q.full & ~rd_hold);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        ctrl_rd                    = '0;
        ctrl_rd[CTRL_RUN]          = s_q.run;
        ctrl_rd[CTRL_IE]           = s_q.ie;
        ctrl_rd[CTRL_MEAS]         = s_q.meas;
        ctrl_rd[CTRL_ESEL +: 2]    = s_q.esel;
        ctrl_rd[CTRL_TSEL +: SEL_W] = s_q.tsel;
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_CTRL: rdata_o = ctrl_rd;
            ADDR_STAT: begin
                rdata_o[ST_UF]   = s_q.uf;
                rdata_o[ST_DONE] = s_q.done;
                rdata_o[ST_FULL] = s_q.full;
            end
            ADDR_HOLD: rdata_o = s_q.hold;
            default:   rdata_o = '0;
        endcase
    end

    assign irq_o = s_q.ie & (s_q.uf | s_q.done | s_q.full);
endmodule

// File: rtl/pwc_timer_chk.sv
module pwc_timer_chk
    import pwc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic             rd_en_i,
    input logic [1:0]       addr_i,
    input logic             wd_run,
    input logic             wd_ie,
    input logic             wd_uf,
    input logic             irq_o,
    input logic [CNT_W-1:0] cnt_q,
    input logic             run_q,
    input logic             meas_q,
    input logic             tick,
    input logic             uf_q,
    input logic             done_q,
    input logic             full_q
);
    logic wr_ctrl, wr_stat, stop_wr;
    assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
    assign wr_stat = wr_en_i && (addr_i == ADDR_STAT);
    assign stop_wr = wr_ctrl && !wd_run;

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !meas_q && tick && cnt_q != '0 && !stop_wr) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    assert_uf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !meas_q && tick && cnt_q == CNT_W'(1) && !stop_wr) |=> uf_q);

    assert_stop_no_uf_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wr && !uf_q) |=> !uf_q);

    assert_stop_no_cmp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wr && !done_q && !full_q) |=> (!done_q && !full_q));

    assert_full_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_q) |-> done_q);

    assert_full_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_q) |-> $past(rd_en_i && addr_i == ADDR_HOLD));

    assert_write1_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wd_uf && uf_q) |=> uf_q);

    assert_hold_stopped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_ctrl) |=> $stable(cnt_q));

    assert_ie_pending_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wd_ie && (uf_q || done_q)) |=> irq_o);
endmodule

bind pwc_timer pwc_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wd_run  (wdata_i[pwc_pkg::CTRL_RUN]),
    .wd_ie   (wdata_i[pwc_pkg::CTRL_IE]),
    .wd_uf   (wdata_i[pwc_pkg::ST_UF]),
    .irq_o   (irq_o),
    .cnt_q   (s_q.cnt),
    .run_q   (s_q.run),
    .meas_q  (s_q.meas),
    .tick    (tick_hit),
    .uf_q    (s_q.uf),
    .done_q  (s_q.done),
    .full_q  (s_q.full)
);

// File: tb/tb_pwc_timer.sv
module tb_pwc_timer;
    import pwc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int NT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NT-1:0] tick_i = '0;
    logic          pulse_i = 1'b0;
    logic          wr_en_i = 1'b0;
    logic          rd_en_i = 1'b0;
    logic [1:0]    addr_i = '0;
    logic [CW-1:0] wdata_i = '0;
    logic [CW-1:0] rdata_o;
    logic          irq_o;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwc_timer #(.CNT_W(CW), .NUM_TICKS(NT)) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pulse_i(pulse_i),
        .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    function automatic logic [7:0] ctrl_word(bit run, bit ie, bit meas, logic [1:0] es, logic [1:0] ts);
        return {1'b0, ts, es, meas, ie, run};
    endfunction

    function automatic int exp_capture(int w);
        return (w - 1) % 256;
    endfunction

    function automatic int exp_status(int w);
        return 6 + (((w - 1) >= 255) ? 1 : 0);
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(posedge clk); #1;
        wr_en_i = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en_i = 1'b1; addr_i = a;
        #1 d = rdata_o;
        @(posedge clk); #1;
        rd_en_i = 1'b0;
    endtask

    task automatic read_stat(output int st);
        logic [7:0] d;
        rd(ADDR_STAT, d);
        st = int'(d[2:0]);
    endtask

    task automatic tick_once(int sel);
        @(negedge clk);
        tick_i = NT'(1) << sel;
        @(posedge clk); #1;
        tick_i = '0;
    endtask

    task automatic noise(int sel);
        @(negedge clk);
        tick_i = NT'($urandom) & ~(NT'(1) << sel);
        @(posedge clk); #1;
        tick_i = '0;
    endtask

    task automatic count_to_uf(int sel, bit with_noise, output int k);
        int st;
        k = 0;
        while (k < 300) begin
            if (with_noise) noise(sel);
            tick_once(sel);
            k++;
            read_stat(st);
            if (st[ST_UF]) break;
        end
    endtask

    task automatic interval_run(int r, int sel, bit check_first);
        int n;
        wr(ADDR_HOLD, 8'(r));
        wr(ADDR_CTRL, ctrl_word(1, 0, 0, 2'b00, 2'(sel)));
        idle(2);
        count_to_uf(sel, 0, n);
        if (check_first) chk("R2", "ticks to first underflow", n, r);
        wr(ADDR_STAT, 8'h00);
        count_to_uf(sel, 0, n);
        chk("R2", "ticks per reloaded period", n, r);
        wr(ADDR_STAT, 8'h00);
        count_to_uf(sel, 1, n);
        chk("R3", "period with other tick lines active", n, r);
        wr(ADDR_STAT, 8'h00);
        wr(ADDR_CTRL, 8'h00);
    endtask

    task automatic measure(logic [1:0] es, int w, output int cap, output int st);
        logic [7:0] d;
        wr(ADDR_CTRL, 8'h00);
        wr(ADDR_STAT, 8'h00);
        pulse_i = (es == 2'b01);
        idle(5);
        tick_i = '1;
        wr(ADDR_CTRL, ctrl_word(1, 0, 1, es, 2'b00));
        idle(3);
        @(negedge clk) pulse_i = ~pulse_i;
        if (es[1]) begin
            repeat (2) @(negedge clk);
            pulse_i = 1'b0;
            repeat (w - 2) @(negedge clk);
            pulse_i = 1'b1;
            repeat (2) @(negedge clk);
            pulse_i = 1'b0;
        end else begin
            repeat (w) @(negedge clk);
            pulse_i = ~pulse_i;
        end
        idle(6);
        read_stat(st);
        rd(ADDR_HOLD, d);
        cap = int'(d);
        tick_i = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [7:0] d;
        int st, cap, last_cap, n;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(ADDR_CTRL, d); chk("R1", "control after reset", int'(d), 0);
        rd(ADDR_STAT, d); chk("R1", "status after reset", int'(d), 0);
        rd(ADDR_HOLD, d); chk("R1", "hold after reset", int'(d), 0);
        chk("R1", "irq after reset", int'(irq_o), 0);

        // R2/R3 directed and random interval runs
        interval_run(6, 2, 1);
        interval_run(1, 0, 0);
        for (int i = 0; i < 3; i++)
            interval_run(1 + int'($urandom % 12), int'($urandom % NT), 0);

        // stop coincident with underflow (R9), hold while stopped (R11)
        wr(ADDR_HOLD, 8'd5);
        wr(ADDR_CTRL, ctrl_word(1, 0, 0, 2'b00, 2'd1));
        count_to_uf(1, 0, n);
        wr(ADDR_STAT, 8'h00);
        repeat (4) tick_once(1);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = ADDR_CTRL; wdata_i = ctrl_word(0, 0, 0, 2'b00, 2'd1);
        tick_i = NT'(2);
        @(posedge clk); #1;
        wr_en_i = 1'b0; tick_i = '0;
        read_stat(st); chk("R9", "underflow after stop in same cycle", st, 0);
        repeat (3) tick_once(1);
        read_stat(st); chk("R11", "ticks while stopped", st, 0);
        wr(ADDR_CTRL, ctrl_word(1, 0, 0, 2'b00, 2'd1));
        idle(2);
        tick_once(1);
        read_stat(st); chk("R11", "resume from held count of one", st, 1);
        chk("R12", "irq with enable off", int'(irq_o), 0);

        // set beats clear (R8)
        repeat (4) tick_once(1);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = ADDR_STAT; wdata_i = 8'h00;
        tick_i = NT'(2);
        @(posedge clk); #1;
        wr_en_i = 1'b0; tick_i = '0;
        read_stat(st); chk("R8", "underflow set vs clear", st, 1);

        // write one has no effect (R6), enable with pending flag (R12)
        wr(ADDR_STAT, 8'hFF);
        read_stat(st); chk("R6", "status after writing ones", st, 1);
        wr(ADDR_CTRL, ctrl_word(0, 1, 0, 2'b00, 2'd1));
        chk("R12", "irq one cycle after enabling", int'(irq_o), 1);
        wr(ADDR_STAT, 8'h00);
        read_stat(st); chk("R6", "status after writing zero", st, 0);
        chk("R12", "irq after flags cleared", int'(irq_o), 0);
        wr(ADDR_CTRL, 8'h00);

        // measurement modes (R4, R5, R7)
        measure(2'b00, 10, cap, st);
        chk("R4", "rise to fall capture", cap, exp_capture(10));
        chk("R5", "status after completion", st, exp_status(10));
        read_stat(st); chk("R7", "status after hold read", st, 2);
        wr(ADDR_STAT, 8'h00);
        read_stat(st); chk("R6", "complete cleared by zero write", st, 0);

        measure(2'b01, 25, cap, st);
        chk("R4", "fall to rise capture", cap, exp_capture(25));
        measure(2'b10, 40, cap, st);
        chk("R4", "rise to rise capture", cap, exp_capture(40));
        measure(2'b11, 12, cap, st);
        chk("R4", "select 11 rise to rise capture", cap, exp_capture(12));
        measure(2'b00, 300, cap, st);
        chk("R5", "long pulse capture wraps", cap, exp_capture(300));
        chk("R5", "long pulse status with underflow", st, exp_status(300));
        last_cap = cap;

        // stop coincident with completion (R10)
        wr(ADDR_CTRL, 8'h00);
        wr(ADDR_STAT, 8'h00);
        pulse_i = 1'b0;
        idle(5);
        tick_i = '1;
        wr(ADDR_CTRL, ctrl_word(1, 0, 1, 2'b00, 2'b00));
        idle(3);
        @(negedge clk) pulse_i = 1'b1;
        repeat (20) @(negedge clk);
        pulse_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = ADDR_CTRL; wdata_i = ctrl_word(0, 0, 1, 2'b00, 2'b00);
        @(posedge clk); #1;
        wr_en_i = 1'b0;
        idle(5);
        tick_i = '0;
        read_stat(st); chk("R10", "flags after stop at completion", st, 0);
        rd(ADDR_HOLD, d); chk("R10", "hold unchanged", int'(d), last_cap);

        // random pulse widths and edge selections (R4)
        for (int i = 0; i < 6; i++) begin
            logic [1:0] es;
            int w;
            es = 2'($urandom % 4);
            w = 4 + int'($urandom % 200);
            measure(es, w, cap, st);
            chk("R4", "random width capture", cap, exp_capture(w));
            chk("R5", "random width status", st, exp_status(w));
        end

        report();
        $finish;
    end
endmodule